// File: doc/BRIEF.md
# Performance monitor counter unit

This block counts micro-architectural events for software profiling. It holds four programmable 32-bit event counters and one 32-bit cycle counter. Software reaches every register through a plain register bus: an address, a write strobe, write data and a combinational read-data return. The core drives a vector of single-cycle event pulses, one bit per event code. Each event counter is programmed with the code it listens to. The counters run only while the global enable is set and their own bit in the enable mask is set.

Event counters are reached indirectly. Software first writes an index to the select register. The event-type and counter-data addresses then act on that one counter. The cycle counter can be slowed by a divide-by-64 prescaler. The enable mask is write-one-to-set. The overflow flags are write-one-to-clear. There is no back-pressure: a write takes effect at the clock edge where the strobe is high, and read data follows the address in the same cycle.

Top module: `pmu_counter_unit`

## Requirements
- R1: After reset, every readable register (addresses 0 to 6 and 8) returns zero.
- R2: When control bit 0 (address 0) is clear, no counter changes, whatever event pulses arrive.
- R3: Writing a 1 to control bit 1 clears all four event counters at that clock edge, even if an increment is due in the same cycle. Control bits 1 and 2 always read back as zero, and bits 0 and 3 read back as written.
- R4: Writing a 1 to control bit 2 clears the cycle counter (address 6) and its prescaler. With control bit 3 clear, an enabled cycle counter adds one on every clock edge.
- R5: With control bit 3 set, the enabled cycle counter adds one on every 64th enabled clock edge.
- R6: The enable mask (address 1) sets each written 1 in bits 0 to 3 (event counters) and bit 31 (cycle counter). Written zeros change nothing. A read returns the mask, and a counter whose bit is clear does not count.
- R7: When a counter steps from 0xFFFFFFFF to 0, its overflow flag is set (bit i for event counter i, bit 31 for the cycle counter; address 2). Writing 1s to address 2 clears those flags. A wrap in the same cycle as a clear leaves the flag set.
- R8: The select register (address 3, bits 1:0) picks the event counter that the event-type register (address 4, bits 3:0) and the counter-data register (address 5) read and write.
- R9: An enabled event counter programmed with code c adds one for each cycle in which event input bit c is high. Codes 0 to 11 are valid, and code 0 is the software-increment input. Codes 12 to 15 never count.
- R10: The event-ID word (address 7) reads 0x00000FFF, with one bit per implemented code. The second ID word (address 8) and unmapped addresses read zero. Addresses 5 and 6 can be written to preload the selected event counter and the cycle counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_we | input | 1 | Write strobe, one write per high cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| evt_in | input | 12 | Event pulses, bit c is code c |

## Verification
Some properties are checked on every cycle by the assertions. A disabled counter holds its value, and a clear always leaves zero. An enabled event step adds exactly one. The divided cycle counter holds between prescaler terminal counts. A wrap always raises its overflow flag, and the enable mask never loses a bit. Other behaviour only the bench scenarios can show. These are the exact counts produced by mixed event codes, the indirect select path, a reset and an event arriving together, overflow clear and wrap arriving together, and the exact divide-by-64 count over a long window.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
  localparam logic [ADDR_W-1:0] A_ENSET = 4'd1;
  localparam logic [ADDR_W-1:0] A_OVF   = 4'd2;
  localparam logic [ADDR_W-1:0] A_SEL   = 4'd3;
  localparam logic [ADDR_W-1:0] A_ETYPE = 4'd4;
  localparam logic [ADDR_W-1:0] A_ECNT  = 4'd5;
  localparam logic [ADDR_W-1:0] A_CYC   = 4'd6;
  localparam logic [ADDR_W-1:0] A_ID0   = 4'd7;
  localparam logic [ADDR_W-1:0] A_ID1   = 4'd8;

  localparam int unsigned CB_EN     = 0;
  localparam int unsigned CB_EVRST  = 1;
  localparam int unsigned CB_CYCRST = 2;
  localparam int unsigned CB_DIV    = 3;
endpackage

// File: rtl/pmu_evt_ctr.sv
module pmu_evt_ctr #(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned N_CODES = 12,
  parameter int unsigned CODE_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [N_CODES-1:0] evt_vec,
  input  logic [CODE_W-1:0] type_code,
  input  logic              clr,
  input  logic              ld,
  input  logic [CNT_W-1:0]  ld_val,
  output logic [CNT_W-1:0]  count,
  output logic              wrap
);
  localparam int unsigned PAD_W = (1 << CODE_W) - N_CODES;

  logic [(1<<CODE_W)-1:0] evt_pad;
  logic                   inc;

  assign evt_pad = {{PAD_W{1'b0}}, evt_vec};
  assign inc     = en & evt_pad[type_code];
  assign wrap    = inc & ~clr & ~ld & (&count);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (clr)    count <= '0;
    else if (ld)     count <= ld_val;
    else if (inc)    count <= count + 1'b1;
  end

  AST_EVT_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr && !ld) |=> $stable(count)); // R2
  AST_EVT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0)); // R3
  AST_EVT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && !ld) |=> (count == $past(count) + 1'b1)); // R9
endmodule

// File: rtl/pmu_cyc_ctr.sv
module pmu_cyc_ctr #(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned PRESC_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             div,
  input  logic             clr,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  logic [PRESC_W-1:0] presc;
  logic               tick;

  assign tick = en & (~div | (&presc));
  assign wrap = tick & ~clr & ~ld & (&count);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            presc <= '0;
    else if (clr)          presc <= '0;
    else if (en && div)    presc <= presc + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (clr)    count <= '0;
    else if (ld)     count <= ld_val;
    else if (tick)   count <= count + 1'b1;
  end

  AST_CYC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0)); // R4
  AST_CYC_PRESC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && div && !(&presc) && !clr && !ld) |=> $stable(count)); // R5
  AST_CYC_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr && !ld) |=> $stable(count)); // R2
endmodule

// File: rtl/pmu_counter_unit.sv
module pmu_counter_unit
  import pmu_pkg::*;
#(
  parameter int unsigned N_CTR      = 4,
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned N_CODES    = 12,
  parameter int unsigned CODE_W     = 4,
  parameter int unsigned PRESC_LOG2 = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [N_CODES-1:0] evt_in
);
  localparam int unsigned SEL_W = (N_CTR > 1) ? $clog2(N_CTR) : 1;
  localparam int unsigned CYC_BIT = DATA_W - 1;
  localparam logic [DATA_W-1:0] IMPL_MASK =
    (DATA_W'(1) << CYC_BIT) | ((DATA_W'(1) << N_CTR) - 1);
  localparam logic [DATA_W-1:0] ID_WORD = (DATA_W'(1) << N_CODES) - 1;

  logic              ctl_en_q, ctl_div_q;
  logic [DATA_W-1:0] enmask_q, ovf_q, wrap_vec;
  logic [SEL_W-1:0]  sel_q;
  logic [CODE_W-1:0] etype_q [N_CTR];
  logic [CNT_W-1:0]  ecnt [N_CTR];
  logic [N_CTR-1:0]  ewrap;
  logic [CNT_W-1:0]  ccnt;
  logic              cwrap;

  logic wr_ctrl, wr_enset, wr_ovf, wr_sel, wr_etype, wr_ecnt, wr_cyc;
  logic ev_clr, cy_clr;

  assign wr_ctrl  = bus_we && (bus_addr == A_CTRL);
  assign wr_enset = bus_we && (bus_addr == A_ENSET);
  assign wr_ovf   = bus_we && (bus_addr == A_OVF);
  assign wr_sel   = bus_we && (bus_addr == A_SEL);
  assign wr_etype = bus_we && (bus_addr == A_ETYPE);
  assign wr_ecnt  = bus_we && (bus_addr == A_ECNT);
  assign wr_cyc   = bus_we && (bus_addr == A_CYC);
  assign ev_clr   = wr_ctrl && bus_wdata[CB_EVRST];
  assign cy_clr   = wr_ctrl && bus_wdata[CB_CYCRST];

  // control, select and enable-mask registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_en_q  <= 1'b0;
      ctl_div_q <= 1'b0;
      sel_q     <= '0;
      enmask_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        ctl_en_q  <= bus_wdata[CB_EN];
        ctl_div_q <= bus_wdata[CB_DIV];
      end
      if (wr_sel)   sel_q    <= bus_wdata[SEL_W-1:0];
      if (wr_enset) enmask_q <= enmask_q | (bus_wdata & IMPL_MASK);
    end
  end

  // overflow flags: wrap sets, write-one clears, set wins
  always_comb begin
    wrap_vec                = '0;
    wrap_vec[N_CTR-1:0]     = ewrap;
    wrap_vec[CYC_BIT]       = cwrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= '0;
    else        ovf_q <= (ovf_q & ~(wr_ovf ? bus_wdata : '0)) | wrap_vec;
  end

  // event counters
  for (genvar gi = 0; gi < N_CTR; gi++) begin : g_ctr
    logic hit_sel;
    assign hit_sel = (sel_q == SEL_W'(gi));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   etype_q[gi] <= '0;
      else if (wr_etype && hit_sel) etype_q[gi] <= bus_wdata[CODE_W-1:0];
    end

    pmu_evt_ctr #(
      .CNT_W   (CNT_W),
      .N_CODES (N_CODES),
      .CODE_W  (CODE_W)
    ) u_evt (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (ctl_en_q & enmask_q[gi]),
      .evt_vec   (evt_in),
      .type_code (etype_q[gi]),
      .clr       (ev_clr),
      .ld        (wr_ecnt && hit_sel),
      .ld_val    (bus_wdata[CNT_W-1:0]),
      .count     (ecnt[gi]),
      .wrap      (ewrap[gi])
    );
  end

  pmu_cyc_ctr #(
    .CNT_W   (CNT_W),
    .PRESC_W (PRESC_LOG2)
  ) u_cyc (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (ctl_en_q & enmask_q[CYC_BIT]),
    .div    (ctl_div_q),
    .clr    (cy_clr),
    .ld     (wr_cyc),
    .ld_val (bus_wdata[CNT_W-1:0]),
    .count  (ccnt),
    .wrap   (cwrap)
  );

  // read mux
  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_CTRL: begin
        bus_rdata[CB_EN]  = ctl_en_q;
        bus_rdata[CB_DIV] = ctl_div_q;
      end
      A_ENSET: bus_rdata = enmask_q;
      A_OVF:   bus_rdata = ovf_q;
      A_SEL:   bus_rdata[SEL_W-1:0]  = sel_q;
      A_ETYPE: bus_rdata[CODE_W-1:0] = etype_q[sel_q];
      A_ECNT:  bus_rdata[CNT_W-1:0]  = ecnt[sel_q];
      A_CYC:   bus_rdata[CNT_W-1:0]  = ccnt;
      A_ID0:   bus_rdata = ID_WORD;
      default: bus_rdata = '0;
    endcase
  end

  AST_OVF_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (|wrap_vec) |=> ((ovf_q & $past(wrap_vec)) == $past(wrap_vec))); // R7
  AST_ENMASK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((enmask_q & $past(enmask_q)) == $past(enmask_q))); // R6
  AST_OVF_ONLY_IMPL: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ovf_q & ~IMPL_MASK) == '0)); // R7
endmodule

// File: tb/test_pmu_counter_unit.sv
`timescale 1ns/1ps
module test_pmu_counter_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [11:0] evt_in = '0;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  bit rd_pend = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  pmu_counter_unit i_pmu_counter_unit (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in)
  );

  // monitor: pops expected items and compares away from the clock edge
  always @(negedge clk) begin
    if (rd_pend && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (bus_rdata !== e) begin
        bad++;
        $display("FAIL %s: actual=0x%08h expected=0x%08h", t, bus_rdata, e);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [11:0] e);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1; evt_in = e;
    @(posedge clk); #1;
    bus_we = 1'b0; evt_in = '0;
  endtask

  task automatic pulse(input logic [11:0] e);
    evt_in = e;
    @(posedge clk); #1;
    evt_in = '0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
    bus_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    rd_pend = 1'b1;
    @(posedge clk); #1;
    rd_pend = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 / R10 reset state and ID words
    rd(4'd0, 32'h0, "R1 ctrl");
    rd(4'd1, 32'h0, "R1 enable mask");
    rd(4'd2, 32'h0, "R1 overflow");
    rd(4'd3, 32'h0, "R1 select");
    rd(4'd4, 32'h0, "R1 event type");
    rd(4'd5, 32'h0, "R1 event count");
    rd(4'd6, 32'h0, "R1 cycle count");
    rd(4'd7, 32'h00000FFF, "R10 id word 0");
    rd(4'd8, 32'h0, "R10 id word 1");
    rd(4'd12, 32'h0, "R10 unmapped");
    // R8 program event types through select
    wr(4'd3, 0, 0); wr(4'd4, 8, 0);
    wr(4'd3, 1, 0); wr(4'd4, 9, 0);
    wr(4'd3, 2, 0); wr(4'd4, 0, 0);
    wr(4'd3, 3, 0); wr(4'd4, 12, 0);
    rd(4'd4, 32'd12, "R8 type of ctr3");
    rd(4'd3, 32'd3, "R8 select readback");
    wr(4'd3, 1, 0);
    rd(4'd4, 32'd9, "R8 type of ctr1");
    // R6 partial enable mask
    wr(4'd1, 32'h1, 0);
    rd(4'd1, 32'h1, "R6 mask bit0");
    wr(4'd0, 32'h1, 0);
    pulse(12'h100);
    pulse(12'h200);
    wr(4'd0, 32'h0, 0);
    wr(4'd3, 0, 0);
    rd(4'd5, 32'd1, "R6 enabled ctr0 counted");
    wr(4'd3, 1, 0);
    rd(4'd5, 32'd0, "R6 masked ctr1 idle");
    wr(4'd1, 32'h8000000E, 0);
    rd(4'd1, 32'h8000000F, "R6 set ones");
    wr(4'd1, 32'h0, 0);
    rd(4'd1, 32'h8000000F, "R6 zeros no effect");
    // R2 disabled counters ignore events
    pulse(12'hFFF);
    wr(4'd3, 0, 0);
    rd(4'd5, 32'd1, "R2 ctr0 held while disabled");
    // R9 mixed event codes
    wr(4'd0, 32'h1, 0);
    pulse(12'h100); pulse(12'h100);
    pulse(12'h200); pulse(12'h200);
    pulse(12'h001);
    pulse(12'hFFF);
    wr(4'd0, 32'h0, 0);
    wr(4'd3, 0, 0); rd(4'd5, 32'd4, "R9 ctr0 code 8");
    wr(4'd3, 1, 0); rd(4'd5, 32'd3, "R9 ctr1 code 9");
    wr(4'd3, 2, 0); rd(4'd5, 32'd2, "R9 ctr2 code 0");
    wr(4'd3, 3, 0); rd(4'd5, 32'd0, "R9 ctr3 code 12 never");
    // R3 event reset, readback of self-clearing bits
    wr(4'd0, 32'hF, 0);
    rd(4'd0, 32'h9, "R3 ctrl readback");
    wr(4'd0, 32'h0, 0);
    wr(4'd3, 0, 0); rd(4'd5, 32'd0, "R3 ctr0 cleared");
    wr(4'd3, 2, 0); rd(4'd5, 32'd0, "R3 ctr2 cleared");
    // R3 reset beats simultaneous increment
    wr(4'd3, 0, 0);
    wr(4'd0, 32'h1, 0);
    wr(4'd0, 32'h3, 12'h100);
    wr(4'd0, 32'h0, 0);
    rd(4'd5, 32'd0, "R3 reset priority");
    // R4 cycle reset and undivided counting
    wr(4'd0, 32'h4, 0);
    rd(4'd6, 32'd0, "R4 cycle cleared");
    wr(4'd0, 32'h1, 0);
    idle(9);
    wr(4'd0, 32'h0, 0);
    rd(4'd6, 32'd10, "R4 cycle per clock");
    // R5 divide by 64
    wr(4'd0, 32'h4, 0);
    wr(4'd0, 32'h9, 0);
    idle(199);
    wr(4'd0, 32'h0, 0);
    rd(4'd6, 32'd3, "R5 divided cycle");
    // R7 event counter wrap
    wr(4'd3, 0, 0);
    wr(4'd5, 32'hFFFFFFFF, 0);
    wr(4'd0, 32'h1, 0);
    pulse(12'h100);
    wr(4'd0, 32'h0, 0);
    rd(4'd2, 32'h1, "R7 ctr0 overflow");
    rd(4'd5, 32'd0, "R7 ctr0 wrapped");
    // R7 cycle counter wrap
    wr(4'd6, 32'hFFFFFFFF, 0);
    wr(4'd0, 32'h1, 0);
    wr(4'd0, 32'h0, 0);
    rd(4'd2, 32'h80000001, "R7 cycle overflow");
    rd(4'd6, 32'd0, "R10 cycle preload wrapped");
    wr(4'd2, 32'h1, 0);
    rd(4'd2, 32'h80000000, "R7 clear bit0");
    wr(4'd2, 32'h80000000, 0);
    rd(4'd2, 32'h0, "R7 clear bit31");
    // R7 set wins over clear
    wr(4'd5, 32'hFFFFFFFF, 0);
    wr(4'd0, 32'h1, 0);
    wr(4'd2, 32'h1, 12'h100);
    wr(4'd0, 32'h0, 0);
    rd(4'd2, 32'h1, "R7 wrap beats clear");
    idle(2);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule